// File: doc/BRIEF.md
# LCD AC-Drive Polarity and Sync-Loss Controller

This block sets the drive polarity of a liquid crystal panel and keeps that polarity alternating when the video input is lost. It runs on the master pixel clock. It takes a one-cycle line-start strobe from the horizontal timing chain and a one-cycle vertical reset pulse from the sync separator. Two static selects set its behaviour: one picks the video standard and the other picks how often the polarity flips. The polarity output either flips on every line or flips once per field. Each flip lands one master clock after the line boundary at which the vertical clocks change.

A line counter measures the gap between vertical resets. The counter's period is 269 lines for NTSC and 321 lines for PAL. When a full period passes with no vertical reset, the block declares a no-signal condition. It then drops an enable, which the pad logic uses to tri-state the phase-comparator output. The same counter then runs free and wraps at each period. At every wrap it raises a one-line substitute vertical reference, which the vertical pulse generators use in place of the missing sync. The field-rate flips then follow these wraps, so the panel stays AC-driven. The first real vertical reset ends the no-signal condition and restarts the counter from that pulse. The no-signal flag and the enable change only at line boundaries.

Top module: `panel_acdrive_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after release, the outputs are: `frp` 0, `no_sig` 0, `vref_stb` 0, `pd_oe` 1.
- R2: With `field_inv` low, `frp` inverts once for every line strobe. The change appears on the second rising edge that samples the strobe, not on the first.
- R3: With `field_inv` high and a signal present, `frp` inverts once per field. This happens on the first line strobe at or after a vertical reset, one clock later. Other line strobes leave `frp` unchanged.
- R4: With `pal_sel` low (NTSC), `no_sig` rises on the 269th line strobe that follows a vertical reset, provided no further reset has arrived. It is still low after the 268th.
- R5: With `pal_sel` high (PAL), the same rule as R4 applies with 321 lines: `no_sig` rises on the 321st strobe and is still low after the 320th.
- R6: `pd_oe` is low exactly while `no_sig` is high (low means the phase-comparator output is tri-stated).
- R7: The line counter wraps every period (269 or 321 strobes) with no vertical reset. Each wrap, including the one that declares no-signal, raises `vref_stb` for one line, from the wrapping strobe to the next strobe.
- R8: A vertical reset ends the no-signal state at the next line strobe, or at the same strobe if the two coincide. The counter restarts from that reset, so the next wrap comes one full period after it.
- R9: `no_sig` changes only on edges that sample a line strobe. A vertical reset arriving mid-line does not change it before the next strobe.
- R10: With `field_inv` high and no signal, `frp` inverts once at each counter wrap and is unchanged on the other lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_stb | input | 1 | One-cycle line-start strobe (vertical clock change point) |
| vreset | input | 1 | One-cycle vertical reset pulse from the sync separator |
| pal_sel | input | 1 | 1 selects PAL (321-line period), 0 selects NTSC (269-line period) |
| field_inv | input | 1 | 1 selects inversion per field, 0 per line |
| frp | output | 1 | AC-drive polarity |
| no_sig | output | 1 | No-signal flag |
| vref_stb | output | 1 | Substitute vertical reference, high for one line after each counter wrap |
| pd_oe | output | 1 | Phase-comparator output enable, low tri-states it |

## Verification
The properties assume that `line_stb` and `vreset` are single-cycle pulses. They also assume that `pal_sel` and `field_inv` do not change while a polarity flip is still in flight. The period checks further assume that `pal_sel` holds steady between two vertical resets. The directed tests meet these conditions by construction. Every strobe and reset is a one-cycle pulse followed by an idle cycle. The mode selects are changed only between scenarios, after all pending flips have settled. A strobe and a reset share a cycle only in the one scenario that targets their coincidence.

// File: rtl/acd_pkg.sv
// Shared constants for the AC-drive polarity controller.
// Assumes: line periods are given in line strobes, vertical reset to wrap.
package acd_pkg;
    localparam int unsigned NTSC_LINES_DEF = 269;
    localparam int unsigned PAL_LINES_DEF  = 321;
endpackage

// File: rtl/acd_line_counter.sv
// Auxiliary vertical line counter. Counts line strobes since the last
// vertical reset and wraps at the period of the selected standard.
// A wrap means a whole period passed with no vertical reset.
// Assumes: line_stb and vreset are single-cycle pulses; a reset wins
// over a coincident strobe.
module acd_line_counter #(
    parameter int unsigned NTSC_LINES = acd_pkg::NTSC_LINES_DEF,
    parameter int unsigned PAL_LINES  = acd_pkg::PAL_LINES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb,
    input  logic vreset,
    input  logic pal_sel,
    output logic wrap
);
    localparam int unsigned MAXP = (PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES;
    localparam int unsigned CW   = $clog2(MAXP);
    localparam logic [CW-1:0] NTSC_LAST = CW'(NTSC_LINES - 1);
    localparam logic [CW-1:0] PAL_LAST  = CW'(PAL_LINES - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_idx;

    // Last line index of the selected standard, and the wrap condition.
    always_comb begin
        last_idx = pal_sel ? PAL_LAST : NTSC_LAST;
        wrap     = line_stb && !vreset && (cnt_q >= last_idx);
    end

    // Line count: cleared by a vertical reset, advanced by each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (vreset)
            cnt_q <= '0;
        else if (line_stb)
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/acd_signal_monitor.sv
// Tracks the presence of a vertical signal. Enters no-signal on a counter
// wrap and leaves it on the first line boundary at or after a vertical
// reset. Produces the one-line substitute reference and the field event.
// Assumes: wrap is only asserted together with line_stb.
module acd_signal_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb,
    input  logic vreset,
    input  logic wrap,
    output logic no_sig,
    output logic vref_stb,
    output logic field_evt
);
    logic vr_pend_q;

    // Field boundary: a line strobe that closes a field, real or substitute.
    always_comb field_evt = line_stb && (wrap || vreset || vr_pend_q);

    // Remember a mid-line vertical reset until the next line boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vr_pend_q <= 1'b0;
        else if (line_stb)
            vr_pend_q <= 1'b0;
        else if (vreset)
            vr_pend_q <= 1'b1;
    end

    // No-signal flag, updated on line boundaries only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            no_sig <= 1'b0;
        else if (line_stb) begin
            if (wrap)
                no_sig <= 1'b1;
            else if (vreset || vr_pend_q)
                no_sig <= 1'b0;
        end
    end

    // Substitute reference: high for the line that starts at a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vref_stb <= 1'b0;
        else if (line_stb)
            vref_stb <= wrap;
    end
endmodule

// File: rtl/acd_polarity_gen.sv
// AC-drive polarity generator. Picks the flip event (each line or each
// field boundary), holds it for one clock and then inverts the output,
// so the change lands one clock after the vertical clock change point.
// Assumes: field_inv is stable around a flip.
module acd_polarity_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb,
    input  logic field_evt,
    input  logic field_inv,
    output logic frp
);
    logic flip;
    logic flip_q;

    // Flip request for the selected inversion mode.
    always_comb flip = field_inv ? field_evt : line_stb;

    // One-clock lag behind the change point.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flip_q <= 1'b0;
        else
            flip_q <= flip;
    end

    // Polarity register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frp <= 1'b0;
        else if (flip_q)
            frp <= ~frp;
    end
endmodule

// File: rtl/panel_acdrive_ctrl.sv
// Top of the AC-drive polarity and sync-loss controller. Joins the
// auxiliary line counter, the signal monitor and the polarity generator.
// Assumes: single-cycle line and vertical reset pulses on the pixel clock.
module panel_acdrive_ctrl #(
    parameter int unsigned NTSC_LINES = acd_pkg::NTSC_LINES_DEF,
    parameter int unsigned PAL_LINES  = acd_pkg::PAL_LINES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb,
    input  logic vreset,
    input  logic pal_sel,
    input  logic field_inv,
    output logic frp,
    output logic no_sig,
    output logic vref_stb,
    output logic pd_oe
);
    logic wrap;
    logic field_evt;

    acd_line_counter #(
        .NTSC_LINES(NTSC_LINES),
        .PAL_LINES (PAL_LINES)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_stb(line_stb),
        .vreset  (vreset),
        .pal_sel (pal_sel),
        .wrap    (wrap)
    );

    acd_signal_monitor u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_stb (line_stb),
        .vreset   (vreset),
        .wrap     (wrap),
        .no_sig   (no_sig),
        .vref_stb (vref_stb),
        .field_evt(field_evt)
    );

    acd_polarity_gen u_pol (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_stb (line_stb),
        .field_evt(field_evt),
        .field_inv(field_inv),
        .frp      (frp)
    );

    // Phase-comparator drive enable, released while no signal is present.
    always_comb pd_oe = !no_sig;
endmodule

// File: rtl/acd_checker.sv
// Property checker for panel_acdrive_ctrl, attached by bind.
// Keeps its own count of lines since the last vertical reset.
module acd_checker #(
    parameter int unsigned NTSC_LINES = acd_pkg::NTSC_LINES_DEF,
    parameter int unsigned PAL_LINES  = acd_pkg::PAL_LINES_DEF
) (
    input logic clk,
    input logic rst_n,
    input logic line_stb,
    input logic vreset,
    input logic pal_sel,
    input logic field_inv,
    input logic frp,
    input logic no_sig,
    input logic vref_stb
);
    int unsigned lines_seen;
    int unsigned period;

    // Period of the selected standard.
    always_comb period = pal_sel ? PAL_LINES : NTSC_LINES;

    // Independent count of strobes since the last reset, modulo the period.
    always_ff @(posedge clk) begin
        if (!rst_n || vreset)
            lines_seen <= 0;
        else if (line_stb)
            lines_seen <= (lines_seen + 1 >= period) ? 0 : lines_seen + 1;
    end

    // R9
    no_sig_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_stb |=> $stable(no_sig));

    // R4 R5
    period_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && !vreset && lines_seen + 1 >= period) |=> (no_sig && vref_stb));

    // R7
    vref_only_without_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vref_stb |-> no_sig);

    // R7
    loss_marks_reference_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(no_sig) |-> vref_stb);

    // R2
    line_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && !field_inv) |=> ##1 (frp != $past(frp)));

    // R2 R3
    flip_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frp != $past(frp)) |-> $past(line_stb, 2));

    // R8
    resume_on_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (no_sig && line_stb && vreset) |=> !no_sig);
endmodule

bind panel_acdrive_ctrl acd_checker #(
    .NTSC_LINES(NTSC_LINES),
    .PAL_LINES (PAL_LINES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_stb (line_stb),
    .vreset   (vreset),
    .pal_sel  (pal_sel),
    .field_inv(field_inv),
    .frp      (frp),
    .no_sig   (no_sig),
    .vref_stb (vref_stb)
);

// File: tb/panel_acdrive_ctrl_test.sv
// Directed bench for panel_acdrive_ctrl: one task per scenario.
module panel_acdrive_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_stb = 1'b0;
    logic vreset = 1'b0;
    logic pal_sel = 1'b0;
    logic field_inv = 1'b0;
    logic frp, no_sig, vref_stb, pd_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    panel_acdrive_ctrl uut (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vreset(vreset),
        .pal_sel(pal_sel), .field_inv(field_inv),
        .frp(frp), .no_sig(no_sig), .vref_stb(vref_stb), .pd_oe(pd_oe)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // n line strobes, each a one-cycle pulse plus two idle cycles.
    task automatic lines(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) line_stb = 1'b1;
            @(negedge clk) line_stb = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic vpulse();
        @(negedge clk) vreset = 1'b1;
        @(negedge clk) vreset = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        lines(2);
        chk("R1", "frp in reset", frp, 1'b0);
        chk("R1", "no_sig in reset", no_sig, 1'b0);
        chk("R1", "vref_stb in reset", vref_stb, 1'b0);
        chk("R1", "pd_oe in reset", pd_oe, 1'b1);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "frp after release", frp, 1'b0);
        chk("R1", "pd_oe after release", pd_oe, 1'b1);
    endtask

    task automatic t_line_mode();
        logic f;
        field_inv = 1'b0;
        pal_sel = 1'b0;
        vpulse();
        f = frp;
        @(negedge clk) line_stb = 1'b1;
        @(negedge clk) line_stb = 1'b0;
        chk("R2", "frp at change point", frp, f);
        @(negedge clk);
        chk("R2", "frp one clock later", frp, ~f);
        for (int i = 0; i < 3; i++) begin
            f = frp;
            lines(1);
            chk("R2", "frp each line", frp, ~f);
        end
    endtask

    task automatic t_field_mode();
        logic f;
        field_inv = 1'b1;
        f = frp;
        vpulse();
        chk("R3", "frp held until line boundary", frp, f);
        lines(1);
        chk("R3", "frp flips at field", frp, ~f);
        lines(3);
        chk("R3", "frp steady within field", frp, ~f);
    endtask

    task automatic t_ntsc_loss();
        field_inv = 1'b0;
        pal_sel = 1'b0;
        vpulse();
        lines(268);
        chk("R4", "no_sig after 268 lines", no_sig, 1'b0);
        chk("R6", "pd_oe with signal", pd_oe, 1'b1);
        lines(1);
        chk("R4", "no_sig after 269 lines", no_sig, 1'b1);
        chk("R6", "pd_oe without signal", pd_oe, 1'b0);
        chk("R7", "vref at declaring wrap", vref_stb, 1'b1);
        lines(1);
        chk("R7", "vref lasts one line", vref_stb, 1'b0);
        lines(267);
        chk("R7", "vref quiet mid-period", vref_stb, 1'b0);
        lines(1);
        chk("R7", "vref at free-run wrap", vref_stb, 1'b1);
        vpulse();
        chk("R9", "no_sig held off boundary", no_sig, 1'b1);
        chk("R6", "pd_oe held off boundary", pd_oe, 1'b0);
        lines(1);
        chk("R8", "no_sig cleared at next line", no_sig, 1'b0);
        chk("R6", "pd_oe restored", pd_oe, 1'b1);
        lines(267);
        chk("R8", "resynced count not expired", no_sig, 1'b0);
        lines(1);
        chk("R8", "resynced count expires", no_sig, 1'b1);
    endtask

    task automatic t_pal_loss();
        logic f;
        field_inv = 1'b1;
        pal_sel = 1'b1;
        vpulse();
        lines(1);
        chk("R8", "PAL resume", no_sig, 1'b0);
        f = frp;
        lines(319);
        chk("R5", "no_sig after 320 lines", no_sig, 1'b0);
        chk("R3", "frp steady over field", frp, f);
        lines(1);
        chk("R5", "no_sig after 321 lines", no_sig, 1'b1);
        chk("R10", "frp flips at wrap", frp, ~f);
        lines(320);
        chk("R10", "frp steady between wraps", frp, ~f);
        lines(1);
        chk("R10", "frp flips at next wrap", frp, f);
        chk("R7", "vref at PAL wrap", vref_stb, 1'b1);
    endtask

    task automatic t_coincide();
        @(negedge clk) begin line_stb = 1'b1; vreset = 1'b1; end
        @(negedge clk) begin line_stb = 1'b0; vreset = 1'b0; end
        chk("R8", "coincident reset clears now", no_sig, 1'b0);
        @(negedge clk);
        lines(320);
        chk("R8", "count restarted at coincidence", no_sig, 1'b0);
        lines(1);
        chk("R8", "expiry one period later", no_sig, 1'b1);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_line_mode();
        t_field_mode();
        t_ntsc_loss();
        t_pal_loss();
        t_coincide();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule